// File: doc/BRIEF.md
# Byte-Lane Static Memory Model

This block is a synthesizable, clock-sampled functional model of a 16-bit-wide static memory with byte-lane control. A system model or an FPGA prototype uses it wherever a discrete asynchronous memory with split byte enables would sit on a board. It has two select inputs of opposite polarity: an active-low select and an active-high select. The device is enabled only when both are asserted. It also has an active-low write strobe, an active-low output enable and one active-low enable for each byte lane.

On each rising clock edge the block samples the control inputs. From them it decodes standby, write, read, or selected-but-not-driving. A write stores only the lanes whose enables are low. A read registers the addressed word and drives only the enabled lanes on the shared bus. Every other lane floats. The drive enables are also gated by the current write strobe, so the bus is released in the same cycle that a write begins. The depth is a parameter, and the address width is derived from it. The default depth is small so the model stays cheap to build. The full-size organization is 512K words, which needs 19 address bits.

Top module: `bytelane_sram`

## Requirements
- R1: When the active-low select is high or the active-high select is low at a clock edge, nothing is stored, and `rd_lane_en` is 2'b00 after that edge.
- R2: A clock edge with the device selected and `wr_n` low stores data whatever the value of `out_n`.
- R3: During a write, `lo_n` low stores `dq[7:0]` and `hi_n` low stores `dq[15:8]` at `addr`. A lane whose enable is high keeps its previous contents.
- R4: A clock edge with the device selected, `out_n` low and `wr_n` high is a read. After that edge, `rd_lane_en[0]` equals the inverse of `lo_n` and `rd_lane_en[1]` equals the inverse of `hi_n`. Each enabled lane carries the stored byte on both `rd_data` and `dq`.
- R5: When the device is selected and not writing, `rd_lane_en` is 2'b00 after the edge if `out_n` is high or if both byte enables are high.
- R6: While the device is selected and `wr_n` is low, `rd_lane_en` is 2'b00 in that same cycle, even if the previous cycle was a read.
- R7: While `rst_n` is low, `rd_lane_en` is 2'b00, and `rd_data` is 16'h0000 at the first edge after reset asserts.
- R8: `addr` is clog2(DEPTH) bits wide. Word 0 and word DEPTH-1 are distinct, independent locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset of the output registers |
| addr | input | AW | Word address, AW = clog2(DEPTH) |
| sel_n | input | 1 | Active-low device select |
| sel_hi | input | 1 | Active-high device select |
| wr_n | input | 1 | Active-low write strobe |
| out_n | input | 1 | Active-low output enable |
| hi_n | input | 1 | Active-low upper byte-lane enable |
| lo_n | input | 1 | Active-low lower byte-lane enable |
| dq | inout | 16 | Shared bidirectional data bus |
| rd_data | output | 16 | Registered read word |
| rd_lane_en | output | 2 | Per-lane drive enables; bit 1 is the upper lane, bit 0 the lower |

## Verification
The visible state is the registered lane-enable pair and the stored words. A wrong lane-enable bit shows on `rd_lane_en` and on the bus one edge after the read or deselect that should have set it. A lane that was written wrongly only appears when that word is read back. Because of that, the vectors interleave partial-lane writes with reads of both single lanes and of the whole word at the same address. A missing write gate would show as contention in the first cycle of a write that follows a read. That case is checked before the next edge.

// File: rtl/bytelane_sram.sv
module bytelane_sram #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          sel_n,
  input  logic          sel_hi,
  input  logic          wr_n,
  input  logic          out_n,
  input  logic          hi_n,
  input  logic          lo_n,
  inout  wire  [15:0]   dq,
  output logic [15:0]   rd_data,
  output logic [1:0]    rd_lane_en
);

  logic [15:0] mem [DEPTH];
  logic [1:0]  lane_q;
  logic        sel, wr, rd;

  assign sel = ~sel_n & sel_hi;
  assign wr  = sel & ~wr_n;
  assign rd  = sel & wr_n & ~out_n;

  always_ff @(posedge clk) begin
    if (wr && !lo_n) mem[addr][7:0]  <= dq[7:0];
    if (wr && !hi_n) mem[addr][15:8] <= dq[15:8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q  <= 2'b00;
      rd_data <= 16'h0000;
    end else begin
      lane_q <= rd ? ~{hi_n, lo_n} : 2'b00;
      if (rd) rd_data <= mem[addr];
    end
  end

  assign rd_lane_en = lane_q & {2{~wr}};

  assign dq[7:0]  = rd_lane_en[0] ? rd_data[7:0]  : 8'hzz;
  assign dq[15:8] = rd_lane_en[1] ? rd_data[15:8] : 8'hzz;

endmodule

// File: rtl/bytelane_sram_chk.sv
module bytelane_sram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_n,
  input logic       sel_hi,
  input logic       wr_n,
  input logic       out_n,
  input logic       hi_n,
  input logic       lo_n,
  input logic [1:0] rd_lane_en
);

  p_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n || !sel_hi) |=> (rd_lane_en == 2'b00));

  p_lane_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sel_hi && wr_n && !out_n) |=>
      (rd_lane_en == ({!$past(hi_n), !$past(lo_n)} & {2{!(!sel_n && sel_hi && !wr_n)}})));

  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sel_hi && wr_n && (out_n || (hi_n && lo_n))) |=> (rd_lane_en == 2'b00));

  p_no_drive_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sel_hi && !wr_n) |-> (rd_lane_en == 2'b00));

  p_lane_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lane_en != 2'b00) |-> $past(!sel_n && sel_hi && wr_n && !out_n));

endmodule

bind bytelane_sram bytelane_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel_hi(sel_hi), .wr_n(wr_n),
  .out_n(out_n), .hi_n(hi_n), .lo_n(lo_n), .rd_lane_en(rd_lane_en)
);

// File: tb/sim_bytelane_sram.sv
module sim_bytelane_sram;
  localparam int DEPTH = 1024;
  localparam int AW = $clog2(DEPTH);
  localparam int NV = 18;

  typedef struct packed {
    logic          s_n, s_hi, w_n, o_n, h_n, l_n;
    logic [AW-1:0] a;
    logic [15:0]   wd;
    logic [1:0]    een;
    logic [15:0]   edat;
    logic [3:0]    req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 10'd5,    16'hA5C3, 2'b00, 16'h0000, 4'd2}, // R2 write, out_n high
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 10'd5,    16'h0000, 2'b11, 16'hA5C3, 4'd4}, // R4 full read
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0, 10'd5,    16'hFF11, 2'b00, 16'h0000, 4'd3}, // R3 low lane write
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 10'd5,    16'h0000, 2'b11, 16'hA511, 4'd3}, // R3 high lane kept
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 10'd5,    16'h3C77, 2'b00, 16'h0000, 4'd2}, // R2 write, out_n low
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 10'd5,    16'h0000, 2'b11, 16'h3C11, 4'd3}, // R3 low lane kept
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0, 10'd5,    16'h0000, 2'b01, 16'h3C11, 4'd4}, // R4 low lane only
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b1, 10'd5,    16'h0000, 2'b10, 16'h3C11, 4'd4}, // R4 high lane only
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 10'd5,    16'h0000, 2'b00, 16'h0000, 4'd5}, // R5 out_n high
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b1, 10'd5,    16'h0000, 2'b00, 16'h0000, 4'd5}, // R5 both lanes off
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 10'd5,    16'h0000, 2'b00, 16'h0000, 4'd1}, // R1 low select off
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 10'd5,    16'h0000, 2'b00, 16'h0000, 4'd1}, // R1 high select off
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 10'd5,    16'h0000, 2'b00, 16'h0000, 4'd1}, // R1 write while deselected
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 10'd5,    16'h0000, 2'b11, 16'h3C11, 4'd1}, // R1 word unchanged
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 10'd1023, 16'hBEEF, 2'b00, 16'h0000, 4'd8}, // R8 top word
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 10'd0,    16'h1234, 2'b00, 16'h0000, 4'd8}, // R8 word 0
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 10'd1023, 16'h0000, 2'b11, 16'hBEEF, 4'd8}, // R8 read top
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 10'd0,    16'h0000, 2'b11, 16'h1234, 4'd8}  // R8 read 0
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic sel_n = 1'b1, sel_hi = 1'b0, wr_n = 1'b1, out_n = 1'b1, hi_n = 1'b1, lo_n = 1'b1;
  logic [15:0] tb_dq = 16'h0000;
  logic tb_drive = 1'b0;
  wire  [15:0] dq;
  logic [15:0] rd_data;
  logic [1:0]  rd_lane_en;
  int tests = 0;
  int fails = 0;

  assign dq = tb_drive ? tb_dq : 16'hzzzz;

  always #4 clk = ~clk;

  bytelane_sram #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .sel_hi(sel_hi),
    .wr_n(wr_n), .out_n(out_n), .hi_n(hi_n), .lo_n(lo_n), .dq(dq),
    .rd_data(rd_data), .rd_lane_en(rd_lane_en)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    sel_n = v.s_n; sel_hi = v.s_hi; wr_n = v.w_n; out_n = v.o_n;
    hi_n = v.h_n; lo_n = v.l_n; addr = v.a;
    tb_dq = v.wd; tb_drive = !v.w_n;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R7 lane enables in reset", {14'h0, rd_lane_en}, 16'h0000);
    check("R7 read data in reset", rd_data, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check($sformatf("R%0d vec%0d lanes", VECS[i].req, i), {14'h0, rd_lane_en}, {14'h0, VECS[i].een});
      if (VECS[i].een[0]) begin
        check($sformatf("R%0d vec%0d low byte", VECS[i].req, i), {8'h0, rd_data[7:0]}, {8'h0, VECS[i].edat[7:0]});
        check($sformatf("R%0d vec%0d bus low", VECS[i].req, i), {8'h0, dq[7:0]}, {8'h0, VECS[i].edat[7:0]});
      end
      if (VECS[i].een[1]) begin
        check($sformatf("R%0d vec%0d high byte", VECS[i].req, i), {8'h0, rd_data[15:8]}, {8'h0, VECS[i].edat[15:8]});
        check($sformatf("R%0d vec%0d bus high", VECS[i].req, i), {8'h0, dq[15:8]}, {8'h0, VECS[i].edat[15:8]});
      end
    end

    // R6: a write right after a read must release the bus before the next edge
    apply(VECS[1]);
    check("R6 read before write", {14'h0, rd_lane_en}, 16'h0003);
    @(negedge clk);
    wr_n = 1'b0; out_n = 1'b0; tb_dq = 16'h5A5A; tb_drive = 1'b1;
    #1;
    check("R6 same-cycle release", {14'h0, rd_lane_en}, 16'h0000);
    @(posedge clk);
    #2;
    check("R6 release held", {14'h0, rd_lane_en}, 16'h0000);
    @(negedge clk);
    wr_n = 1'b1; tb_drive = 1'b0;
    @(posedge clk);
    #2;
    check("R6 write landed", rd_data, 16'h5A5A);

    // R7: reset asserted during an active read clears the enables
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R7 mid-run reset lanes", {14'h0, rd_lane_en}, 16'h0000);
    @(posedge clk);
    #2;
    check("R7 mid-run reset data", rd_data, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    check("R7 read resumes", rd_data, 16'h5A5A);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule